// File: doc/BRIEF.md
# Refresh Buffer Cursor Access Unit

This unit sits between a host (or a drawing engine) and a bit-planed video memory. It keeps a pair of cursor registers (the X cap and the Y cap) together with a small control word, and it turns each host access into one memory request at the cursor position. The access type chosen by the host decides whether the cursor then moves along the major axis, the minor axis, both, or stays put. This lets lines, spans and fills be drawn by streaming pixel data through one address.

Writes pass through a per-plane write mask. A stippled variant of each access can veto the write through the top bit of a rotating 8-bit pattern register. A multi-write variant asks the memory to store the same pixel value across a run of horizontally adjacent pixels. The memory side is a simple request/grant port. The memory applies the plane mask and the run length.

Top module: `rb_cursor_unit`

## Requirements
- R1: After reset the X and Y caps and the control word read 0, the write mask and the stipple pattern read all ones, `h_ready` is 1, `h_rvalid` is 0 and `m_req` is 0.
- R2: With `h_sel[4:3]`=00 an access reaches a register chosen by `h_sel[2:0]`: 0 control, 1 write mask, 2 stipple, 3 X cap, 4 Y cap. A write takes effect on the accepting edge. A read returns the value on `h_rdata` with `h_rvalid` high in the following cycle. Control bits: bit 0 set makes Y the major axis, bit 1 set makes the major axis decrement, bit 2 set makes the minor axis decrement, and bit 3 set selects the short vertical format.
- R3: `h_sel[4:3]` selects plain (01), stippled (10) or multi-write (11) video access. `h_sel[1:0]` selects the cursor move after the access: 00 none, 01 major, 10 minor, 11 both. Each move is one step in the direction the control word gives.
- R4: The X cap wraps modulo `X_EXTENT`. The Y cap wraps modulo `Y_EXTENT`, or modulo `Y_SHORT` when control bit 3 is set. Incrementing from extent-1 gives 0, and decrementing from 0 gives extent-1.
- R5: A video read returns the pixel at the cursor position before the move, on `h_rdata` with `h_rvalid` high in the cycle after the grant.
- R6: A video write changes only the planes whose write-mask bit is 1. The other planes keep their old contents.
- R7: A stippled write is suppressed (plane mask 0) when stipple bit 7 is 0. Every stippled access, read or write and whether or not it wrote, rotates the pattern left by one. The cursor moves either way.
- R8: A multi-write stores the pixel into `MULTI_SPAN` pixels, starting at the X cap with increasing X and wrapping at the X extent. A read of the multi-write type touches one pixel.
- R9: `m_req` stays high with a stable address and data until `m_gnt`. The caps change on the grant edge. `h_ready` is low from the accepting edge until the grant, so an access that waits s stall cycles keeps the unit busy for s+1 cycles, and back-to-back accesses walk contiguous pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request |
| h_write | input | 1 | 1 for write, 0 for read |
| h_sel | input | 5 | Register or access-type select |
| h_wdata | input | CAP_W | Host write data |
| h_ready | output | 1 | Unit can accept an access |
| h_rvalid | output | 1 | Read data valid |
| h_rdata | output | CAP_W | Read data |
| m_req | output | 1 | Memory request |
| m_gnt | input | 1 | Memory accepts the request |
| m_we | output | 1 | Request is a write |
| m_x | output | CAP_W | Pixel column |
| m_y | output | CAP_W | Pixel row |
| m_wdata | output | PIX_W | Pixel write value |
| m_pmask | output | PIX_W | Planes to write |
| m_span | output | $clog2(MULTI_SPAN+1) | Pixels to write from m_x rightward |
| m_rdata | input | PIX_W | Pixel read value, valid with m_gnt |

## Verification
The bench sweeps all 16 control words against all four move codes on a 16x12 memory with a 10-line short format. Each start position sits one step from the wrap edge of its direction. This separates swapped major/minor routing, a wrong direction bit, a wrong wrap constant and a missing short-format switch. The memory stall length varies across the sweep, so a cap that moves before the grant shows up. Separate patterns cover a mask that keeps half the planes, the stipple pattern A5 over eight writes followed by a stippled read, and a multi-write that crosses the right edge, which tells a correct wrap from a truncated or misplaced run.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    AK_REG   = 2'd0,
    AK_PLAIN = 2'd1,
    AK_STIP  = 2'd2,
    AK_MULTI = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic fmt_short;
    logic minor_dec;
    logic major_dec;
    logic major_y;
  } ctrl_t;

  localparam logic [2:0] RS_CTRL  = 3'd0;
  localparam logic [2:0] RS_WMASK = 3'd1;
  localparam logic [2:0] RS_STIP  = 3'd2;
  localparam logic [2:0] RS_XCAP  = 3'd3;
  localparam logic [2:0] RS_YCAP  = 3'd4;
endpackage

// File: rtl/rbc_cap_counter.sv
module rbc_cap_counter #(
  parameter int CAP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CAP_W-1:0] ld_val,
  input  logic             step,
  input  logic             dec,
  input  logic [CAP_W:0]   extent,
  output logic [CAP_W-1:0] cap
);
  logic [CAP_W:0] ext_m1;
  assign ext_m1 = extent - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
    end else if (ld) begin
      cap <= ld_val;
    end else if (step) begin
      if (dec) begin
        cap <= (cap == '0) ? ext_m1[CAP_W-1:0] : cap - 1'b1;
      end else begin
        cap <= ({1'b0, cap} >= ext_m1) ? '0 : cap + 1'b1;
      end
    end
  end

  // R4
  cap_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && ({1'b0, cap} < extent)) |=> ({1'b0, cap} < $past(extent)));

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !ld) |=> $stable(cap));
endmodule

// File: rtl/rbc_stipple.sv
module rbc_stipple #(
  parameter int STIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [STIP_W-1:0] ld_val,
  input  logic              rot,
  output logic [STIP_W-1:0] pat
);
  always_ff @(posedge clk) begin
    if (rst)      pat <= '1;
    else if (ld)  pat <= ld_val;
    else if (rot) pat <= {pat[STIP_W-2:0], pat[STIP_W-1]};
  end

  // R7
  stip_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rot && !ld) |=> ($countones(pat) == $countones($past(pat))));
endmodule

// File: rtl/rbc_mem_port.sv
module rbc_mem_port #(
  parameter int CAP_W  = 11,
  parameter int PIX_W  = 8,
  parameter int SPAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              l_we,
  input  logic [CAP_W-1:0]  l_x,
  input  logic [CAP_W-1:0]  l_y,
  input  logic [PIX_W-1:0]  l_wdata,
  input  logic [PIX_W-1:0]  l_pmask,
  input  logic [SPAN_W-1:0] l_span,
  input  logic              m_gnt,
  output logic              m_req,
  output logic              m_we,
  output logic [CAP_W-1:0]  m_x,
  output logic [CAP_W-1:0]  m_y,
  output logic [PIX_W-1:0]  m_wdata,
  output logic [PIX_W-1:0]  m_pmask,
  output logic [SPAN_W-1:0] m_span,
  output logic              done
);
  assign done = m_req && m_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_x     <= '0;
      m_y     <= '0;
      m_wdata <= '0;
      m_pmask <= '0;
      m_span  <= '0;
    end else if (launch) begin
      m_req   <= 1'b1;
      m_we    <= l_we;
      m_x     <= l_x;
      m_y     <= l_y;
      m_wdata <= l_wdata;
      m_pmask <= l_pmask;
      m_span  <= l_span;
    end else if (done) begin
      m_req <= 1'b0;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_gnt) |=> (m_req && $stable(m_x) && $stable(m_y) && $stable(m_wdata)));
endmodule

// File: rtl/rb_cursor_unit.sv
module rb_cursor_unit
  import rbc_pkg::*;
#(
  parameter int CAP_W      = 11,
  parameter int PIX_W      = 8,
  parameter int X_EXTENT   = 1280,
  parameter int Y_EXTENT   = 1024,
  parameter int Y_SHORT    = 960,
  parameter int STIP_W     = 8,
  parameter int MULTI_SPAN = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               h_valid,
  input  logic                               h_write,
  input  logic [4:0]                         h_sel,
  input  logic [CAP_W-1:0]                   h_wdata,
  output logic                               h_ready,
  output logic                               h_rvalid,
  output logic [CAP_W-1:0]                   h_rdata,
  output logic                               m_req,
  input  logic                               m_gnt,
  output logic                               m_we,
  output logic [CAP_W-1:0]                   m_x,
  output logic [CAP_W-1:0]                   m_y,
  output logic [PIX_W-1:0]                   m_wdata,
  output logic [PIX_W-1:0]                   m_pmask,
  output logic [$clog2(MULTI_SPAN+1)-1:0]    m_span,
  input  logic [PIX_W-1:0]                   m_rdata
);
  localparam int SPAN_W = $clog2(MULTI_SPAN + 1);
  localparam int EXT_W  = CAP_W + 1;

  ctrl_t             ctrl_q;
  logic [PIX_W-1:0]  wmask_q;
  logic [STIP_W-1:0] stip_pat;
  logic              busy_q;
  acc_kind_t         pend_kind;
  logic [1:0]        pend_adv;
  logic              pend_we;
  logic [CAP_W-1:0]  rdata_q;
  logic              rvalid_q;
  logic [CAP_W-1:0]  reg_rd;

  logic [CAP_W-1:0]  cap     [2];
  logic [EXT_W-1:0]  ext     [2];
  logic              ld      [2];
  logic              stp     [2];
  logic              dir_dec [2];

  acc_kind_t         kind;
  logic              acc, reg_wr, reg_rd_acc, launch, done;
  logic              maj_step, min_step;
  logic [PIX_W-1:0]  l_pmask;
  logic [SPAN_W-1:0] l_span;

  assign kind       = acc_kind_t'(h_sel[4:3]);
  assign acc        = h_valid && !busy_q;
  assign reg_wr     = acc && (kind == AK_REG) && h_write;
  assign reg_rd_acc = acc && (kind == AK_REG) && !h_write;
  assign launch     = acc && (kind != AK_REG);

  assign maj_step = done && pend_adv[0];
  assign min_step = done && pend_adv[1];

  assign stp[0]     = ctrl_q.major_y ? min_step : maj_step;
  assign stp[1]     = ctrl_q.major_y ? maj_step : min_step;
  assign dir_dec[0] = ctrl_q.major_y ? ctrl_q.minor_dec : ctrl_q.major_dec;
  assign dir_dec[1] = ctrl_q.major_y ? ctrl_q.major_dec : ctrl_q.minor_dec;
  assign ld[0]      = reg_wr && (h_sel[2:0] == RS_XCAP);
  assign ld[1]      = reg_wr && (h_sel[2:0] == RS_YCAP);
  assign ext[0]     = EXT_W'(X_EXTENT);
  assign ext[1]     = ctrl_q.fmt_short ? EXT_W'(Y_SHORT) : EXT_W'(Y_EXTENT);

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rbc_cap_counter #(.CAP_W(CAP_W)) i_cap (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld[a]),
      .ld_val (h_wdata),
      .step   (stp[a]),
      .dec    (dir_dec[a]),
      .extent (ext[a]),
      .cap    (cap[a])
    );
  end

  rbc_stipple #(.STIP_W(STIP_W)) i_stip (
    .clk    (clk),
    .rst    (rst),
    .ld     (reg_wr && (h_sel[2:0] == RS_STIP)),
    .ld_val (h_wdata[STIP_W-1:0]),
    .rot    (done && (pend_kind == AK_STIP)),
    .pat    (stip_pat)
  );

  assign l_pmask = ((kind == AK_STIP) && !stip_pat[STIP_W-1]) ? '0 : wmask_q;
  assign l_span  = ((kind == AK_MULTI) && h_write) ? SPAN_W'(MULTI_SPAN) : SPAN_W'(1);

  rbc_mem_port #(.CAP_W(CAP_W), .PIX_W(PIX_W), .SPAN_W(SPAN_W)) i_port (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .l_we    (h_write),
    .l_x     (cap[0]),
    .l_y     (cap[1]),
    .l_wdata (h_wdata[PIX_W-1:0]),
    .l_pmask (l_pmask),
    .l_span  (l_span),
    .m_gnt   (m_gnt),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_x     (m_x),
    .m_y     (m_y),
    .m_wdata (m_wdata),
    .m_pmask (m_pmask),
    .m_span  (m_span),
    .done    (done)
  );

  always_comb begin
    case (h_sel[2:0])
      RS_CTRL:  reg_rd = CAP_W'(ctrl_q);
      RS_WMASK: reg_rd = CAP_W'(wmask_q);
      RS_STIP:  reg_rd = CAP_W'(stip_pat);
      RS_XCAP:  reg_rd = cap[0];
      RS_YCAP:  reg_rd = cap[1];
      default:  reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      wmask_q   <= '1;
      busy_q    <= 1'b0;
      pend_kind <= AK_REG;
      pend_adv  <= '0;
      pend_we   <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (launch) begin
        busy_q    <= 1'b1;
        pend_kind <= kind;
        pend_adv  <= h_sel[1:0];
        pend_we   <= h_write;
      end
      if (done) begin
        busy_q <= 1'b0;
        if (!pend_we) begin
          rdata_q  <= CAP_W'(m_rdata);
          rvalid_q <= 1'b1;
        end
      end
      if (reg_wr && (h_sel[2:0] == RS_CTRL))  ctrl_q  <= ctrl_t'(h_wdata[3:0]);
      if (reg_wr && (h_sel[2:0] == RS_WMASK)) wmask_q <= h_wdata[PIX_W-1:0];
      if (reg_rd_acc) begin
        rdata_q  <= reg_rd;
        rvalid_q <= 1'b1;
      end
    end
  end

  assign h_ready  = !busy_q;
  assign h_rvalid = rvalid_q;
  assign h_rdata  = rdata_q;

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !h_ready);

  // R7
  stip_veto_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && (kind == AK_STIP) && h_write && !stip_pat[STIP_W-1])
      |=> (m_req && m_we && (m_pmask == '0)));

  // R3
  cap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_gnt) |=> ($stable(cap[0]) && $stable(cap[1])));

  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we) |-> (m_span == SPAN_W'(1)));
endmodule

// File: tb/test_rb_cursor_unit.sv
module test_rb_cursor_unit;
  localparam int CW = 11, PW = 8, XE = 16, YE = 12, YS = 10, SPAN = 10;
  localparam int SW = $clog2(SPAN + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, h_valid, h_write, h_ready, h_rvalid;
  logic [4:0]    h_sel;
  logic [CW-1:0] h_wdata, h_rdata, m_x, m_y;
  logic          m_req, m_gnt, m_we;
  logic [PW-1:0] m_wdata, m_pmask, m_rdata;
  logic [SW-1:0] m_span;

  int nchk = 0, nerr = 0, stall = 0, wcnt = 0;
  logic [7:0] mem [YE][XE];

  rb_cursor_unit #(.CAP_W(CW), .PIX_W(PW), .X_EXTENT(XE), .Y_EXTENT(YE),
                   .Y_SHORT(YS), .MULTI_SPAN(SPAN)) i_rb_cursor_unit (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_write(h_write), .h_sel(h_sel),
    .h_wdata(h_wdata), .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .m_req(m_req), .m_gnt(m_gnt), .m_we(m_we), .m_x(m_x), .m_y(m_y),
    .m_wdata(m_wdata), .m_pmask(m_pmask), .m_span(m_span), .m_rdata(m_rdata));

  assign m_gnt   = m_req && (wcnt >= stall);
  assign m_rdata = mem[m_y][m_x];

  always @(posedge clk) begin
    if (m_req && !m_gnt) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (m_req && m_gnt && m_we)
      for (int i = 0; i < int'(m_span); i++)
        mem[m_y][(int'(m_x) + i) % XE] <=
          (mem[m_y][(int'(m_x) + i) % XE] & ~m_pmask) | (m_wdata & m_pmask);
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [4:0] sel, input logic wr, input int d,
                        output int rd, output int busy);
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_sel = sel; h_wdata = CW'(d);
    @(negedge clk);
    h_valid = 1'b0; busy = 0; rd = -1;
    for (int k = 0; k < 1000; k++) begin
      if (h_rvalid) rd = int'(h_rdata);
      if (h_ready) break;
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic wreg(input int r, input int d);
    int rd, b;
    access({2'b00, 3'(r)}, 1'b1, d, rd, b);
  endtask

  function automatic int rreg_sel(input int r);
    return r;
  endfunction

  task automatic rreg(input int r, output int v);
    int b;
    access({2'b00, 3'(rreg_sel(r))}, 1'b0, 0, v, b);
  endtask

  function automatic logic [4:0] vsel(input int kind, input int adv);
    return {2'(kind), 1'b0, 2'(adv)};
  endfunction

  function automatic int nxt(input int v, input bit dec, input int ext);
    if (dec) return (v == 0) ? ext - 1 : v - 1;
    return (v >= ext - 1) ? 0 : v + 1;
  endfunction

  task automatic clear_row(input int y);
    int rd, b;
    wreg(0, 0); wreg(3, 0); wreg(4, y); wreg(1, 8'hFF);
    for (int i = 0; i < XE; i++) access(vsel(1, 1), 1'b1, 0, rd, b);
  endtask

  initial begin
    int v, b, rd;
    rst = 1'b1; h_valid = 1'b0; h_write = 1'b0; h_sel = '0; h_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(h_ready), 1);
    chk("R1 req", int'(m_req), 0);
    chk("R1 rvalid", int'(h_rvalid), 0);
    rreg(0, v); chk("R1 ctrl", v, 0);
    rreg(1, v); chk("R1 wmask", v, 8'hFF);
    rreg(2, v); chk("R1 stipple", v, 8'hFF);
    rreg(3, v); chk("R1 xcap", v, 0);
    rreg(4, v); chk("R1 ycap", v, 0);
    // R2 direct register access
    wreg(3, 7);  rreg(3, v); chk("R2 xcap", v, 7);
    wreg(4, 5);  rreg(4, v); chk("R2 ycap", v, 5);
    wreg(0, 9);  rreg(0, v); chk("R2 ctrl", v, 9);
    wreg(1, 8'h3C); rreg(1, v); chk("R2 wmask", v, 8'h3C);
    wreg(1, 8'hFF);

    // R3 R4 R9 sweep: every control word against every move code
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int adv = 0; adv < 4; adv++) begin
        bit majy, mjd, mnd, xdec, ydec, xs, ys;
        int ye, ex, ey, dat;
        majy = cfg[0]; mjd = cfg[1]; mnd = cfg[2];
        ye   = cfg[3] ? YS : YE;
        xdec = majy ? mnd : mjd;
        ydec = majy ? mjd : mnd;
        xs   = majy ? adv[1] : adv[0];
        ys   = majy ? adv[0] : adv[1];
        ex   = xdec ? 1 : XE - 2;
        ey   = ydec ? 1 : ye - 2;
        wreg(0, cfg); wreg(3, ex); wreg(4, ey);
        stall = (cfg + adv) % 3;
        for (int k = 0; k < 3; k++) begin
          dat = (cfg << 4) | (adv << 2) | k;
          access(vsel(1, adv), 1'b1, dat, rd, b);
          chk("R3 pixel at pre-move cursor", int'(mem[ey][ex]), dat);
          chk("R9 busy cycles", b, stall + 1);
          if (xs) ex = nxt(ex, xdec, XE);
          if (ys) ey = nxt(ey, ydec, ye);
        end
        rreg(3, v); chk("R4 xcap after walk", v, ex);
        rreg(4, v); chk("R4 ycap after walk", v, ey);
      end
    end
    stall = 0;

    // R6 write mask, R5 read before move
    wreg(0, 0); wreg(3, 3); wreg(4, 2); wreg(1, 8'hFF);
    access(vsel(1, 0), 1'b1, 8'hC3, rd, b);
    wreg(1, 8'h0F);
    access(vsel(1, 0), 1'b1, 8'h3C, rd, b);
    chk("R6 masked planes kept", int'(mem[2][3]), 8'hCC);
    wreg(1, 8'hFF);
    stall = 2;
    access(vsel(1, 1), 1'b0, 0, rd, b);
    chk("R5 read value", rd, 8'hCC);
    stall = 0;
    rreg(3, v); chk("R5 cap moved after read", v, 4);

    // R7 stipple veto and rotation
    clear_row(4);
    wreg(3, 0); wreg(2, 8'hA5);
    for (int i = 0; i < 8; i++) access(vsel(2, 1), 1'b1, 8'h77, rd, b);
    for (int i = 0; i < 8; i++)
      chk("R7 stippled pixel", int'(mem[4][i]), ((8'hA5 >> (7 - i)) & 1) ? 8'h77 : 0);
    rreg(3, v); chk("R7 cap moves when vetoed", v, 8);
    rreg(2, v); chk("R7 pattern after 8 rotations", v, 8'hA5);
    access(vsel(2, 0), 1'b0, 0, rd, b);
    rreg(2, v); chk("R7 read rotates pattern", v, 8'h4B);

    // R8 multi-write across the right edge
    clear_row(6);
    wreg(3, XE - 4);
    access(vsel(3, 0), 1'b1, 8'h5A, rd, b);
    for (int i = 0; i < SPAN; i++)
      chk("R8 run pixel", int'(mem[6][(XE - 4 + i) % XE]), 8'h5A);
    chk("R8 pixel past run", int'(mem[6][(XE - 4 + SPAN) % XE]), 0);
    rreg(3, v); chk("R8 cap unmoved", v, XE - 4);
    access(vsel(3, 1), 1'b1, 8'h11, rd, b);
    rreg(3, v); chk("R8 cap one step", v, XE - 3);
    access(vsel(3, 0), 1'b0, 0, rd, b);
    chk("R8 multi read single pixel", rd, 8'h11);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule